// File: doc/BRIEF.md
# Weight-Stationary Matrix Multiply Unit

This block keeps one operand matrix parked inside the unit and streams short vectors of the other operand past it. The parked matrix has `NCHUNK*CROWS` rows of `COLS` signed elements. It is filled by `NCHUNK` consecutive pushes, and each push carries a chunk of `CROWS` rows. Once every chunk is present, each streamed vector produces one signed dot product per parked row, in every row at once.

Two command channels consume streamed vectors. The overwrite channel replaces the per-row accumulators with the fresh dot products. The add channel sums the fresh dot products into the accumulators and then places a copy of the completed row set in a result queue. The host drains the queue through a pop channel, one slice of `ROWS/POP_SPLIT` rows per pop. A normal sequence is an overwrite followed by an add, and that pair yields two pops at the default sizes. Several instances can be loaded with the same parked matrix and driven with different vectors, and each runs on its own.

Top module: `ws_matrix_unit`

## Requirements
- R1: After reset, `mml_ready`, `mma_ready` and `pop_valid` are low, and `push_ready` is high.
- R2: Pushes fill the parked rows in chunk order: the first push fills rows 0..CROWS-1, the next push fills the next CROWS rows, and so on. Within `push_data`, row j of the chunk occupies bits `[j*COLS*DW +: COLS*DW]` and element c of that row occupies `[c*DW +: DW]`. Both multiply channels hold ready low until all NCHUNK chunks are present.
- R3: An accepted overwrite command sets accumulator row r to the sum over c of `row[r][c] * vec[c]`, using signed two's-complement arithmetic at width AW. Element c of a vector is `vec[c*DW +: DW]`. The overwrite enqueues nothing.
- R4: An accepted add command sets each accumulator row to its old value plus the fresh dot product, wrapping modulo 2^AW, and enqueues the updated rows as one result.
- R5: Each result leaves as POP_SPLIT pops, lowest rows first. Row j of a slice is `pop_data[j*AW +: AW]`. `pop_last` is high on the final slice of a result. Results leave in the order they were produced.
- R6: When the queue is empty, `pop_valid` is low and a pop request has no effect.
- R7: When QDEPTH results are queued, `mma_ready` is low, an add request is neither queued nor applied to the accumulators, and overwrite commands are still accepted.
- R8: A push made after all chunks are present restarts loading at chunk 0, so multiply readiness drops until NCHUNK pushes have completed. Reset also restarts loading at chunk 0.
- R9: If both multiply channels are valid in the same cycle, the overwrite is taken and the add is not accepted.
- R10: A multiply accepted in the same cycle as a push uses the parked rows as they were before that push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Parked-operand chunk offered |
| push_ready | output | 1 | Always high; a chunk is taken every cycle |
| push_data | input | CROWS*COLS*DW | One chunk of parked rows |
| mml_valid | input | 1 | Overwrite multiply offered |
| mml_ready | output | 1 | Overwrite multiply can be taken |
| mml_vec | input | COLS*DW | Streamed vector for the overwrite |
| mma_valid | input | 1 | Add multiply offered |
| mma_ready | output | 1 | Add multiply can be taken |
| mma_vec | input | COLS*DW | Streamed vector for the add |
| pop_valid | output | 1 | A result slice is available |
| pop_ready | input | 1 | Host takes the slice |
| pop_data | output | (ROWS/POP_SPLIT)*AW | Current result slice |
| pop_last | output | 1 | Current slice is the last one of its result |

## Verification
Two pairs of events are forced into the same cycle. In the first, a push that restarts loading is issued in the same cycle as an overwrite multiply. The bench then adds a zero vector and pops the result, which must equal the dot products of the old parked rows. Afterwards, readiness must stay low until the reload is complete.

In the second, both multiply channels are driven valid together. No result may appear in the queue from that cycle, and a later zero-vector add must expose the overwrite's products. A full queue with a refused add, and a pop attempted on an empty queue, are checked in the same way through the pop channel.

// File: rtl/wsmu_pkg.sv
package wsmu_pkg;

  typedef enum logic [1:0] {
    MUL_IDLE = 2'd0,
    MUL_LOAD = 2'd1,
    MUL_ACC  = 2'd2
  } mul_op_e;

endpackage

// File: rtl/wsmu_stationary.sv
module wsmu_stationary #(
  parameter int DW     = 8,
  parameter int COLS   = 2,
  parameter int CROWS  = 8,
  parameter int NCHUNK = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               push_valid,
  input  logic [CROWS*COLS*DW-1:0]           push_data,
  output logic                               loaded,
  output logic [NCHUNK*CROWS*COLS*DW-1:0]    st_flat
);
  localparam int RW   = COLS * DW;
  localparam int ROWS = NCHUNK * CROWS;
  localparam int CW   = $clog2(NCHUNK + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] wsel;
  logic [RW-1:0] rows_q [ROWS];

  assign loaded = (cnt_q == CW'(NCHUNK));
  // a push after a full load restarts at chunk 0
  assign wsel   = loaded ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (push_valid) begin
      if (loaded) cnt_q <= CW'(1);
      else        cnt_q <= cnt_q + CW'(1);
    end
  end

  // row storage, no reset so it can map to plain registers or RAM
  always_ff @(posedge clk) begin
    if (push_valid) begin
      for (int i = 0; i < NCHUNK; i++) begin
        if (wsel == CW'(i)) begin
          for (int j = 0; j < CROWS; j++) begin
            rows_q[i*CROWS + j] <= push_data[j*RW +: RW];
          end
        end
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_flat
    assign st_flat[r*RW +: RW] = rows_q[r];
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(NCHUNK)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !loaded) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R2
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    (push_valid && loaded) |=> (cnt_q == CW'(1))); // R8

endmodule

// File: rtl/wsmu_mac_rows.sv
module wsmu_mac_rows #(
  parameter int DW   = 8,
  parameter int COLS = 2,
  parameter int ROWS = 32,
  parameter int AW   = 20
) (
  input  logic [ROWS*COLS*DW-1:0] st_flat,
  input  logic [COLS*DW-1:0]      vec,
  input  logic [ROWS*AW-1:0]      acc_flat,
  input  logic                    add_en,
  output logic [ROWS*AW-1:0]      next_flat
);
  localparam int PW  = 2 * DW;
  localparam int EXT = AW - PW;

  initial begin
    if (EXT < 1) $error("AW must exceed twice DW");
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic signed [PW-1:0] prod [COLS];
    logic        [AW-1:0] dot;

    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign prod[c] = $signed(st_flat[(r*COLS + c)*DW +: DW]) * $signed(vec[c*DW +: DW]);
    end

    always_comb begin
      dot = '0;
      for (int c = 0; c < COLS; c++) begin
        dot = dot + {{EXT{prod[c][PW-1]}}, prod[c]};
      end
    end

    assign next_flat[r*AW +: AW] = add_en ? (acc_flat[r*AW +: AW] + dot) : dot;
  end

endmodule

// File: rtl/wsmu_result_fifo.sv
module wsmu_result_fifo #(
  parameter int W     = 640,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int PTRW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;

  assign full    = (count == CNTW'(DEPTH));
  assign empty   = (count == '0);
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == PTRW'(DEPTH - 1)) ? '0 : wr_ptr + PTRW'(1);
      if (rd_en) rd_ptr <= (rd_ptr == PTRW'(DEPTH - 1)) ? '0 : rd_ptr + PTRW'(1);
      if (wr_en && !rd_en)      count <= count + CNTW'(1);
      else if (rd_en && !wr_en) count <= count - CNTW'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty); // R6
  AST_CNT_TRACK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en) |=> (count == $past(count) + CNTW'(1))); // R4

endmodule

// File: rtl/ws_matrix_unit.sv
module ws_matrix_unit
  import wsmu_pkg::*;
#(
  parameter int DW        = 8,
  parameter int COLS      = 2,
  parameter int CROWS     = 8,
  parameter int NCHUNK    = 4,
  parameter int AW        = 20,
  parameter int POP_SPLIT = 2,
  parameter int QDEPTH    = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                push_valid,
  output logic                                push_ready,
  input  logic [CROWS*COLS*DW-1:0]            push_data,
  input  logic                                mml_valid,
  output logic                                mml_ready,
  input  logic [COLS*DW-1:0]                  mml_vec,
  input  logic                                mma_valid,
  output logic                                mma_ready,
  input  logic [COLS*DW-1:0]                  mma_vec,
  output logic                                pop_valid,
  input  logic                                pop_ready,
  output logic [(NCHUNK*CROWS/POP_SPLIT)*AW-1:0] pop_data,
  output logic                                pop_last
);
  localparam int ROWS  = NCHUNK * CROWS;
  localparam int PROWS = ROWS / POP_SPLIT;
  localparam int PW    = PROWS * AW;
  localparam int HW    = (POP_SPLIT < 2) ? 1 : $clog2(POP_SPLIT);

  logic                       loaded;
  logic [ROWS*COLS*DW-1:0]    st_flat;
  logic [ROWS*AW-1:0]         acc_q;
  logic [ROWS*AW-1:0]         acc_next;
  logic [COLS*DW-1:0]         vec_sel;
  logic                       q_full, q_empty, q_wr, q_rd;
  logic [ROWS*AW-1:0]         q_rdata;
  logic [HW-1:0]              half_q;
  logic                       pop_fire;
  mul_op_e                    op;

  wsmu_stationary #(
    .DW(DW), .COLS(COLS), .CROWS(CROWS), .NCHUNK(NCHUNK)
  ) u_stat (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .loaded(loaded), .st_flat(st_flat)
  );

  // the overwrite channel has priority over the add channel
  always_comb begin
    op = MUL_IDLE;
    if (loaded && mml_valid)                 op = MUL_LOAD;
    else if (loaded && mma_valid && !q_full) op = MUL_ACC;
  end

  assign push_ready = 1'b1;
  assign mml_ready  = loaded;
  assign mma_ready  = loaded && !q_full && !mml_valid;
  assign vec_sel    = (op == MUL_LOAD) ? mml_vec : mma_vec;

  wsmu_mac_rows #(
    .DW(DW), .COLS(COLS), .ROWS(ROWS), .AW(AW)
  ) u_mac (
    .st_flat(st_flat), .vec(vec_sel), .acc_flat(acc_q),
    .add_en(op == MUL_ACC), .next_flat(acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst)                 acc_q <= '0;
    else if (op != MUL_IDLE) acc_q <= acc_next;
  end

  assign q_wr = (op == MUL_ACC);

  wsmu_result_fifo #(
    .W(ROWS*AW), .DEPTH(QDEPTH)
  ) u_fifo (
    .clk(clk), .rst(rst), .wr_en(q_wr), .wr_data(acc_next),
    .rd_en(q_rd), .rd_data(q_rdata), .full(q_full), .empty(q_empty)
  );

  assign pop_valid = !q_empty;
  assign pop_fire  = pop_valid && pop_ready;
  assign pop_last  = (half_q == HW'(POP_SPLIT - 1));
  assign q_rd      = pop_fire && pop_last;
  assign pop_data  = q_rdata[int'(half_q)*PW +: PW];

  always_ff @(posedge clk) begin
    if (rst)           half_q <= '0;
    else if (pop_fire) half_q <= pop_last ? '0 : half_q + HW'(1);
  end

  AST_NO_MUL_UNLOADED: assert property (@(posedge clk) disable iff (rst)
    !loaded |-> (op == MUL_IDLE)); // R2
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op == MUL_IDLE) |=> $stable(acc_q)); // R3
  AST_LOAD_PRIO: assert property (@(posedge clk) disable iff (rst)
    (mml_valid && mml_ready) |-> !(mma_valid && mma_ready)); // R9
  AST_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_data))); // R5

endmodule

// File: tb/ws_matrix_unit_test.sv
`timescale 1ns/1ps
module ws_matrix_unit_test;
  localparam int DW = 8, COLS = 2, CROWS = 8, NCHUNK = 4, AW = 20;
  localparam int ROWS = 32, PROWS = 16, QD = 4;

  // {kind (0 overwrite, 1 add), v1, v0}
  localparam logic [16:0] TBL [11] = '{
    {1'b0, 8'h02, 8'h01}, {1'b1, 8'h00, 8'h00},
    {1'b0, 8'h04, 8'hFD}, {1'b1, 8'hFF, 8'h05},
    {1'b0, 8'h80, 8'h7F}, {1'b1, 8'h7F, 8'h80},
    {1'b0, 8'h00, 8'h00}, {1'b1, 8'h01, 8'h01},
    {1'b1, 8'h00, 8'h02}, {1'b0, 8'hFF, 8'hFF},
    {1'b1, 8'h03, 8'h03}
  };

  logic clk = 0, rst = 1;
  logic push_valid = 0, push_ready;
  logic [CROWS*COLS*DW-1:0] push_data = '0;
  logic mml_valid = 0, mml_ready, mma_valid = 0, mma_ready;
  logic [COLS*DW-1:0] mml_vec = '0, mma_vec = '0;
  logic pop_valid, pop_ready = 0, pop_last;
  logic [PROWS*AW-1:0] pop_data;

  always #2 clk = ~clk;

  ws_matrix_unit uut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .mml_valid(mml_valid), .mml_ready(mml_ready),
    .mml_vec(mml_vec), .mma_valid(mma_valid), .mma_ready(mma_ready),
    .mma_vec(mma_vec), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_data(pop_data), .pop_last(pop_last)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int s_m [ROWS][COLS];
  int acc_m [ROWS];
  int q_m [$];
  int cnt_m = 0, half_m = 0;

  function automatic int sval(int r, int c, int seed);
    return ((r*7 + c*13 + seed*5) % 31) - 15;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; push_valid = 0; mml_valid = 0; mma_valid = 0; pop_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    cnt_m = 0; half_m = 0; q_m.delete();
    for (int r = 0; r < ROWS; r++) acc_m[r] = 0;
  endtask

  // one cycle of commands, then update the model from the requirements
  task automatic cmd(bit pu, int seed, bit l, int lv0, int lv1, bit a, int av0, int av1);
    int ch;
    bit ld;
    ch = (cnt_m == NCHUNK) ? 0 : cnt_m;
    push_valid = pu;
    for (int j = 0; j < CROWS; j++)
      for (int c = 0; c < COLS; c++)
        push_data[(j*COLS + c)*DW +: DW] = 8'(sval(ch*CROWS + j, c, seed));
    mml_valid = l; mml_vec = {8'(lv1), 8'(lv0)};
    mma_valid = a; mma_vec = {8'(av1), 8'(av0)};
    @(negedge clk);
    push_valid = 0; mml_valid = 0; mma_valid = 0;
    ld = (cnt_m == NCHUNK);
    if (l && ld) begin
      for (int r = 0; r < ROWS; r++) acc_m[r] = s_m[r][0]*lv0 + s_m[r][1]*lv1;
    end else if (a && ld && (q_m.size() / ROWS) < QD) begin
      for (int r = 0; r < ROWS; r++) begin
        acc_m[r] = acc_m[r] + s_m[r][0]*av0 + s_m[r][1]*av1;
        q_m.push_back(acc_m[r]);
      end
    end
    if (pu) begin
      for (int j = 0; j < CROWS; j++)
        for (int c = 0; c < COLS; c++) s_m[ch*CROWS + j][c] = sval(ch*CROWS + j, c, seed);
      cnt_m = (cnt_m == NCHUNK) ? 1 : cnt_m + 1;
    end
  endtask

  task automatic pop_one(string req);
    logic [PROWS*AW-1:0] got;
    logic lst;
    bit ok;
    int bad;
    check(pop_valid === 1'b1 && q_m.size() >= ROWS, req, "pop_valid", pop_valid, 1);
    if (q_m.size() < ROWS) return;
    pop_ready = 1;
    got = pop_data; lst = pop_last;
    @(negedge clk);
    pop_ready = 0;
    ok = 1; bad = 0;
    for (int j = 0; j < PROWS; j++) begin
      if (got[j*AW +: AW] !== AW'(q_m[half_m*PROWS + j]) && ok) begin
        ok = 0; bad = j;
      end
    end
    check(ok, req, "slice row", longint'($signed(got[bad*AW +: AW])), q_m[half_m*PROWS + bad]);
    check(lst === (half_m == 1), req, "pop_last", lst, half_m == 1);
    if (half_m == 1) begin
      half_m = 0;
      for (int k = 0; k < ROWS; k++) void'(q_m.pop_front());
    end else half_m = 1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check(mml_ready === 0 && mma_ready === 0, "R1", "mul ready", mml_ready, 0);
    check(pop_valid === 0, "R1", "pop_valid", pop_valid, 0);
    check(push_ready === 1, "R1", "push_ready", push_ready, 1);

    // R2 staged loading
    for (int i = 0; i < 3; i++) cmd(1, 1, 0, 0, 0, 0, 0, 0);
    check(mml_ready === 0 && mma_ready === 0, "R2", "ready after 3 pushes", mml_ready, 0);
    cmd(1, 1, 0, 0, 0, 0, 0, 0);
    check(mml_ready === 1 && mma_ready === 1, "R2", "ready after 4 pushes", mml_ready, 1);

    // R6 pop on an empty queue
    pop_ready = 1;
    check(pop_valid === 0, "R6", "pop_valid empty", pop_valid, 0);
    @(negedge clk);
    pop_ready = 0;
    check(pop_valid === 0, "R6", "pop_valid after empty pop", pop_valid, 0);

    // table walk: R3 overwrite, R4 add, R5 pop order
    for (int i = 0; i < 11; i++) begin
      if (TBL[i][16])
        cmd(0, 0, 0, 0, 0, 1, int'($signed(TBL[i][7:0])), int'($signed(TBL[i][15:8])));
      else
        cmd(0, 0, 1, int'($signed(TBL[i][7:0])), int'($signed(TBL[i][15:8])), 0, 0, 0);
      if (TBL[i][16]) begin
        pop_one("R3 R4 R5");
        pop_one("R3 R4 R5");
      end
    end

    // R7 full queue
    cmd(0, 0, 1, 2, 3, 0, 0, 0);
    cmd(0, 0, 0, 0, 0, 1, 1, 0);
    cmd(0, 0, 0, 0, 0, 1, 0, 1);
    cmd(0, 0, 0, 0, 0, 1, 1, 1);
    cmd(0, 0, 0, 0, 0, 1, -2, 5);
    check(mma_ready === 0, "R7", "mma_ready full", mma_ready, 0);
    check(mml_ready === 1, "R7", "mml_ready full", mml_ready, 1);
    cmd(0, 0, 0, 0, 0, 1, 9, 9);
    for (int i = 0; i < 2*QD; i++) pop_one("R7 R5");
    check(pop_valid === 0, "R7", "refused add queued", pop_valid, 0);
    cmd(0, 0, 0, 0, 0, 1, 0, 0);
    pop_one("R7");
    pop_one("R7");

    // R9 both multiply channels at once
    cmd(0, 0, 1, 4, -2, 1, 7, 7);
    check(pop_valid === 0, "R9", "add taken with overwrite", pop_valid, 0);
    cmd(0, 0, 0, 0, 0, 1, 0, 0);
    pop_one("R9");
    pop_one("R9");

    // R10 / R8 push with multiply in the same cycle, then reload
    cmd(1, 2, 1, -5, 6, 0, 0, 0);
    check(mml_ready === 0, "R8", "ready after restart push", mml_ready, 0);
    for (int i = 0; i < 3; i++) cmd(1, 2, 0, 0, 0, 0, 0, 0);
    check(mml_ready === 1, "R8", "ready after reload", mml_ready, 1);
    cmd(0, 0, 0, 0, 0, 1, 0, 0);
    pop_one("R10");
    pop_one("R10");
    cmd(0, 0, 0, 0, 0, 1, 1, -1);
    pop_one("R2 R10");
    pop_one("R2 R10");

    // R8 reset mid-load
    cmd(1, 3, 0, 0, 0, 0, 0, 0);
    cmd(1, 3, 0, 0, 0, 0, 0, 0);
    do_reset();
    check(mml_ready === 0, "R8", "ready after reset", mml_ready, 0);
    for (int i = 0; i < 3; i++) cmd(1, 4, 0, 0, 0, 0, 0, 0);
    check(mml_ready === 0, "R8", "ready after 3 post-reset pushes", mml_ready, 0);
    cmd(1, 4, 0, 0, 0, 0, 0, 0);
    check(mml_ready === 1, "R8", "ready after 4 post-reset pushes", mml_ready, 1);
    cmd(0, 0, 1, 2, 2, 0, 0, 0);
    cmd(0, 0, 0, 0, 0, 1, 0, 0);
    pop_one("R8");
    pop_one("R8");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule